// File: doc/BRIEF.md
# Cipher Key and Chaining-Value Register Bank

This block holds the 128-bit secret key and the 128-bit chaining value (initialization vector or running counter) used by a block-cipher datapath. Software reaches it over a plain 32-bit register bus that has separate write and read strobes and a read path with no latency. The bank drives the full key and chaining value to the cipher core as two flat 128-bit vectors. When the core finishes a block, it can return a new 128-bit chaining value on a single-cycle strobe.

A two-state controller decides who may touch the stored words. In state `ST_OFF` the engine is stopped, and the host may load the key and the chaining value and may read the chaining value back. Transition `T_START` moves the controller from `ST_OFF` to `ST_RUN`; it fires on a control-register write with bit 0 set. In `ST_RUN` host writes to the key and chaining words are dropped, chaining reads return zero, and only the core may refresh the chaining value. Transition `T_STOP` moves it from `ST_RUN` back to `ST_OFF`; it fires on a control-register write with bit 0 clear. Any other cycle takes the hold transition `T_STAY`. Because the last value the core wrote stays readable after `T_STOP`, software can suspend a long message, save the counter and resume later.

Address map, in byte offsets. Only word-aligned offsets are decoded.
- 0x00: control. Bit 0 is the engine enable.
- 0x10, 0x14, 0x18, 0x1C: key words 0 to 3.
- 0x20, 0x24, 0x28, 0x2C: chaining words 0 to 3.

Top module: `cipher_keyiv_bank`

## Requirements
- R1: After the asynchronous active-low reset, `eng_enable` is 0 and `key_out` and `iv_out` are all zeros.
- R2: A write to offset 0x00 sets `eng_enable` to `bus_wdata[0]` from the next clock edge on. This is transition `T_START` or `T_STOP`. A read of 0x00 returns the enable in bit 0 and zeros in bits 31:1.
- R3: While `eng_enable` is 0, a write to key offset 0x10+4n (n = 0..3) places the data in `key_out[32n+31:32n]` after the clock edge. Word 3 therefore holds bits 127:96.
- R4: While `eng_enable` is 1, host writes to key offsets leave `key_out` unchanged.
- R5: Reads of any key offset always return zero, whatever the enable state.
- R6: While `eng_enable` is 0, a write to chaining offset 0x20+4n places the data in `iv_out[32n+31:32n]` after the clock edge. Word 0 sits at the lowest offset and holds the least significant bits.
- R7: While `eng_enable` is 1, host writes to chaining offsets leave `iv_out` unchanged.
- R8: A read of chaining offset 0x20+4n returns zero while `eng_enable` is 1. While it is 0, the read returns `iv_out[32n+31:32n]`.
- R9: A `core_iv_upd` pulse loads all 128 bits of `core_iv_data` into `iv_out` at the next edge when `eng_enable` is 1. When `eng_enable` is 0 the pulse has no effect.
- R10: After the core has updated the chaining value and `T_STOP` has been taken, chaining reads return the last core-written value. A core update in the same cycle as the stopping write is still taken.
- R11: Reads of unmapped or misaligned offsets return zero, and writes to them change neither `eng_enable`, `key_out` nor `iv_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| core_iv_upd | input | 1 | Core strobe that returns a new chaining value |
| core_iv_data | input | 128 | Chaining value returned by the core |
| eng_enable | output | 1 | Engine enable, high in `ST_RUN` |
| key_out | output | 128 | Full key driven to the core |
| iv_out | output | 128 | Full chaining value driven to the core |

## Verification
The hardest situation to reach is a core update that lands in the same cycle as the `T_STOP` control write, followed by reads while stopped that must return that freshly loaded counter rather than the value the host wrote before. A directed task drives the stopping write and the update strobe on the same edge. Seeded random sequences of enable toggles, core pulses, host writes (including writes to unmapped and misaligned offsets) and reads then move repeatedly between the two states. The bench model follows each of these steps and predicts every read.

// File: rtl/cipher_keyiv_pkg.sv
package cipher_keyiv_pkg;

    // Decoded target of a bus access
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_CTRL = 2'd1,
        RG_KEY  = 2'd2,
        RG_IV   = 2'd3
    } region_e;

    // Run controller states
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

endpackage

// File: rtl/keyiv_addr_decode.sv
module keyiv_addr_decode
    import cipher_keyiv_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NWORDS   = 4,
    parameter int KEY_BASE = 4,   // word index of key word 0
    parameter int IV_BASE  = 8    // word index of chaining word 0
) (
    input  logic [ADDR_W-1:0]         addr_i,
    output region_e                   region_o,
    output logic [$clog2(NWORDS)-1:0] idx_o
);
    localparam int WA    = ADDR_W - 2;
    localparam int IDX_W = $clog2(NWORDS);
    localparam logic [WA-1:0] KEY_LO = WA'(KEY_BASE);
    localparam logic [WA-1:0] KEY_HI = WA'(KEY_BASE + NWORDS - 1);
    localparam logic [WA-1:0] IV_LO  = WA'(IV_BASE);
    localparam logic [WA-1:0] IV_HI  = WA'(IV_BASE + NWORDS - 1);

    logic [WA-1:0] word;
    logic          aligned;

    assign word    = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);

    always_comb begin
        region_o = RG_NONE;
        idx_o    = '0;
        if (aligned) begin
            if (word == '0) begin
                region_o = RG_CTRL;
            end else if (word >= KEY_LO && word <= KEY_HI) begin
                region_o = RG_KEY;
                idx_o    = IDX_W'(word - KEY_LO);
            end else if (word >= IV_LO && word <= IV_HI) begin
                region_o = RG_IV;
                idx_o    = IDX_W'(word - IV_LO);
            end
        end
    end

endmodule

// File: rtl/keyiv_run_fsm.sv
module keyiv_run_fsm
    import cipher_keyiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic ctrl_bit_i,
    output logic en_o
);
    run_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions: T_START, T_STOP, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (ctrl_wr_i && ctrl_bit_i)  state_d = ST_RUN;
            ST_RUN: if (ctrl_wr_i && !ctrl_bit_i) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  en_o = 1'b1;
            default: en_o = 1'b0;
        endcase
    end

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i |=> (en_o == $past(ctrl_bit_i)));

    p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_i |=> $stable(en_o));

endmodule

// File: rtl/keyiv_word_bank.sv
module keyiv_word_bank #(
    parameter int NWORDS  = 4,
    parameter int DW      = 32,
    parameter bit CORE_UPD = 1'b0   // 1: core may reload the whole bank
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      wr_i,
    input  logic [$clog2(NWORDS)-1:0] idx_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic                      upd_i,
    input  logic [NWORDS*DW-1:0]      upd_data_i,
    output logic [NWORDS*DW-1:0]      words_o
);
    localparam int IDX_W = $clog2(NWORDS);

    logic host_ok;
    logic core_ok;

    assign host_ok = wr_i && !en_i;

    generate
        if (CORE_UPD) begin : g_upd_on
            assign core_ok = upd_i && en_i;
        end else begin : g_upd_off
            logic unused_upd;
            assign unused_upd = upd_i ^ (^upd_data_i);
            assign core_ok = 1'b0;
        end
    endgenerate

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_o[w*DW +: DW] <= '0;
            end else if (core_ok) begin
                words_o[w*DW +: DW] <= upd_data_i[w*DW +: DW];
            end else if (host_ok && idx_i == IDX_W'(w)) begin
                words_o[w*DW +: DW] <= wdata_i;
            end
        end
    end

    generate
        if (CORE_UPD) begin : g_chk_iv
            p_host_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && !upd_i) |=> $stable(words_o));
            p_core_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && upd_i) |=> (words_o == $past(upd_data_i)));
            p_core_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!en_i && !wr_i) |=> $stable(words_o));
        end else begin : g_chk_key
            p_key_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
                en_i |=> $stable(words_o));
        end
    endgenerate

endmodule

// File: rtl/cipher_keyiv_bank.sv
module cipher_keyiv_bank
    import cipher_keyiv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 32,
    parameter int NWORDS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic                 core_iv_upd,
    input  logic [NWORDS*DW-1:0] core_iv_data,
    output logic                 eng_enable,
    output logic [NWORDS*DW-1:0] key_out,
    output logic [NWORDS*DW-1:0] iv_out
);
    localparam int IDX_W    = $clog2(NWORDS);
    localparam int KEY_BASE = 4;
    localparam int IV_BASE  = KEY_BASE + NWORDS;

    region_e          region;
    logic [IDX_W-1:0] idx;

    keyiv_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NWORDS  (NWORDS),
        .KEY_BASE(KEY_BASE),
        .IV_BASE (IV_BASE)
    ) u_dec (
        .addr_i  (bus_addr),
        .region_o(region),
        .idx_o   (idx)
    );

    keyiv_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (bus_wr && region == RG_CTRL),
        .ctrl_bit_i(bus_wdata[0]),
        .en_o      (eng_enable)
    );

    keyiv_word_bank #(
        .NWORDS  (NWORDS),
        .DW      (DW),
        .CORE_UPD(1'b0)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (eng_enable),
        .wr_i      (bus_wr && region == RG_KEY),
        .idx_i     (idx),
        .wdata_i   (bus_wdata),
        .upd_i     (1'b0),
        .upd_data_i('0),
        .words_o   (key_out)
    );

    keyiv_word_bank #(
        .NWORDS  (NWORDS),
        .DW      (DW),
        .CORE_UPD(1'b1)
    ) u_iv (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (eng_enable),
        .wr_i      (bus_wr && region == RG_IV),
        .idx_i     (idx),
        .wdata_i   (bus_wdata),
        .upd_i     (core_iv_upd),
        .upd_data_i(core_iv_data),
        .words_o   (iv_out)
    );

    // Read path: key never leaves the block, chaining words only while stopped
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (region)
                RG_CTRL: bus_rdata = {{(DW-1){1'b0}}, eng_enable};
                RG_IV:   bus_rdata = eng_enable ? '0 : iv_out[idx*DW +: DW];
                default: bus_rdata = '0;
            endcase
        end
    end

    p_key_unreadable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && region == RG_KEY) |-> (bus_rdata == '0));

    p_iv_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && eng_enable) |-> (bus_rdata[DW-1:1] == '0));

    p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && region == RG_NONE && !core_iv_upd) |=>
            ($stable(key_out) && $stable(iv_out) && $stable(eng_enable)));

endmodule

// File: tb/sim_cipher_keyiv_bank.sv
module sim_cipher_keyiv_bank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         core_iv_upd = 1'b0;
    logic [127:0] core_iv_data = '0;
    logic         eng_enable;
    logic [127:0] key_out;
    logic [127:0] iv_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic         m_en  = 1'b0;
    logic [127:0] m_key = '0;
    logic [127:0] m_iv  = '0;

    always #2.5 clk = ~clk;

    cipher_keyiv_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_iv_upd(core_iv_upd), .core_iv_data(core_iv_data),
        .eng_enable(eng_enable), .key_out(key_out), .iv_out(iv_out)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the read value, from the address map in the requirements
    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return {31'b0, m_en};
        if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00) return 32'h0;
        if (a >= 8'h20 && a <= 8'h2C && a[1:0] == 2'b00)
            return m_en ? 32'h0 : m_iv[(a - 8'h20) * 8 +: 32];
        return 32'h0;
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h00) m_en = d[0];
        else if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00 && !m_en)
            m_key[(a - 8'h10) * 8 +: 32] = d;
        else if (a >= 8'h20 && a <= 8'h2C && a[1:0] == 2'b00 && !m_en)
            m_iv[(a - 8'h20) * 8 +: 32] = d;
    endtask

    task automatic check_outs(input string req);
        chk({req, " en"},  {127'b0, eng_enable}, {127'b0, m_en});
        chk({req, " key"}, key_out, m_key);
        chk({req, " iv"},  iv_out, m_iv);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, {96'b0, bus_rdata}, {96'b0, m_read(a)});
        bus_rd = 1'b0;
    endtask

    task automatic core_push(input logic [127:0] d);
        @(negedge clk);
        core_iv_upd = 1'b1; core_iv_data = d;
        @(negedge clk);
        core_iv_upd = 1'b0;
        if (m_en) m_iv = d;
    endtask

    task automatic stop_with_push(input logic [127:0] d);
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h0; bus_wr = 1'b1;
        core_iv_upd = 1'b1; core_iv_data = d;
        @(negedge clk);
        bus_wr = 1'b0; core_iv_upd = 1'b0;
        if (m_en) m_iv = d;
        m_en = 1'b0;
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r);
        case (r % 16)
            0:  return 8'h00;
            1:  return 8'h10;  2: return 8'h14;  3: return 8'h18;  4: return 8'h1C;
            5:  return 8'h20;  6: return 8'h24;  7: return 8'h28;  8: return 8'h2C;
            9:  return 8'h04;  10: return 8'h30; 11: return 8'h22; 12: return 8'hFC;
            13: return 8'h0C;  14: return 8'h1E;
            default: return 8'h40;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] cnt;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_outs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1");

        // R3: key word mapping while stopped
        bus_write(8'h10, 32'h0000_1111);
        bus_write(8'h14, 32'h2222_0000);
        bus_write(8'h18, 32'h3333_3333);
        bus_write(8'h1C, 32'hA444_444A);
        chk("R3 key word3 is msb", key_out, 128'hA444_444A_3333_3333_2222_0000_0000_1111);
        // R5: key never readable
        bus_read(8'h1C, "R5 key read stopped");

        // R6: chaining mapping while stopped, R8 readback
        bus_write(8'h20, 32'hC0C0_0001);
        bus_write(8'h2C, 32'hF00D_0003);
        chk("R6 iv word layout", iv_out, 128'hF00D_0003_0000_0000_0000_0000_C0C0_0001);
        bus_read(8'h2C, "R8 iv read stopped");
        bus_read(8'h20, "R8 iv read stopped");

        // R2: start, control readback with stray upper bits written
        bus_write(8'h00, 32'hFFFF_FFF1);
        check_outs("R2 start");
        bus_read(8'h00, "R2 ctrl read");

        // R4 / R7: host writes blocked while running
        bus_write(8'h14, 32'hDEAD_BEEF);
        check_outs("R4 key write blocked");
        bus_write(8'h24, 32'hDEAD_BEEF);
        check_outs("R7 iv write blocked");
        bus_read(8'h24, "R8 iv read running");
        bus_read(8'h10, "R5 key read running");

        // R9: core update accepted while running
        cnt = 128'h0123_4567_89AB_CDEF_0000_0000_0000_0001;
        core_push(cnt);
        check_outs("R9 core load");

        // R10: stop in same cycle as update, then read the counter back
        stop_with_push(cnt + 1);
        check_outs("R10 stop with update");
        for (int i = 0; i < 4; i++) bus_read(8'h20 + 8'(4 * i), "R10 counter readback");

        // R9: update ignored while stopped
        core_push(128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000);
        check_outs("R9 core ignored stopped");

        // R11: unmapped and misaligned offsets
        bus_write(8'h30, 32'h1234_5678);
        bus_write(8'h22, 32'h1234_5678);
        bus_write(8'h01, 32'h0000_0001);
        check_outs("R11 unmapped write");
        bus_read(8'h3C, "R11 unmapped read");
        bus_read(8'h12, "R11 misaligned read");

        // Seeded random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned op;
            op = $urandom % 8;
            case (op)
                0, 1, 2: bus_write(pick_addr($urandom), $urandom);
                3, 4:    bus_read(pick_addr($urandom), "R8 R11 random read");
                5:       core_push({$urandom, $urandom, $urandom, $urandom});
                6:       bus_write(8'h00, {$urandom} & 32'hFFFF_FFFF);
                default: stop_with_push({$urandom, $urandom, $urandom, $urandom});
            endcase
            check_outs("R4 R7 R9 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule